// File: doc/BRIEF.md
# Dual-Modulus Synthesizer Divider Pair

This block holds the two digital dividers of an integer-N frequency synthesizer. The feedback divider counts output periods of an external dual-modulus prescaler (÷16 or ÷17). It steers that prescaler through a modulus-control output, so that one full feedback cycle spans 16·P + A oscillator periods. The reference divider counts enable pulses derived from the reference clock and divides them by R. Both dividers raise a single-cycle pulse at the comparison rate for a downstream phase detector.

Two divide sets are held at the inputs. Each set is one 14-bit feedback word and one 11-bit reference word. A select bit normally chooses between them. A select pin can override the bit when it is actively driven, and a separate drive-valid input tells the block whether the pin is driven or left floating. Each divider loads the chosen set only when it wraps, so a change never shortens or stretches a period that is already running.

All logic runs on one clock. The prescaler output and the reference arrive as one-cycle enables, `pre_pulse` and `ref_pulse`.

Top module: `pll_div_pair`

## Requirements
- R1: A synchronous active-low reset clears both outputs and both counters and loads the currently selected set. After reset, `mod_hi` is 1 exactly when the loaded swallow field is non-zero.
- R2: A feedback word is split into two fields. Bits [3:0] are the swallow count A and bits [13:4] are the main count P, so the word's value is M = 16·P + A.
- R3: Within each feedback cycle, `mod_hi` is 1 during the first A prescaler periods (÷17) and 0 during the remaining P − A periods (÷16).
- R4: `fb_out` pulses once every P `pre_pulse` enables. With the prescaler following `mod_hi`, this is once every 16·P + A oscillator periods.
- R5: `fb_out` is high for exactly one clock cycle. That cycle is the one right after the clock edge that accepted the terminal `pre_pulse`.
- R6: `ref_out` is high for one clock cycle after every R-th `ref_pulse` enable. R is an 11-bit value in the range 2 to 2047.
- R7: The active set is set 1 when (`sel_drv` ? `sel_pin` : `sel_bit`) is 1, and set 2 otherwise.
- R8: A change of the selected set, or of the values inside it, takes effect only at each divider's next wrap. The running period finishes with the old values.
- R9: While no enables arrive, neither divider changes state. `fb_out`, `ref_out` and `mod_hi` hold steady.
- R10: The boundary values are handled: M = 256 (P = 16, A = 0, `mod_hi` never high), M = 16383, R = 2 and R = 2047.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pre_pulse | input | 1 | One-cycle enable marking the end of a prescaler period |
| ref_pulse | input | 1 | One-cycle enable marking one reference period |
| fb_set1 | input | 14 | Feedback word of set 1: {P[9:0], A[3:0]} |
| fb_set2 | input | 14 | Feedback word of set 2: {P[9:0], A[3:0]} |
| ref_set1 | input | 11 | Reference divide value of set 1 |
| ref_set2 | input | 11 | Reference divide value of set 2 |
| sel_bit | input | 1 | Stored set select, 1 = set 1 |
| sel_pin | input | 1 | Select pin level, 1 = set 1 |
| sel_drv | input | 1 | 1 when the select pin is driven and overrides `sel_bit` |
| mod_hi | output | 1 | Prescaler modulus control, 1 = ÷17 |
| fb_out | output | 1 | Feedback divider terminal pulse |
| ref_out | output | 1 | Reference divider terminal pulse |

## Verification
The assertions rely on three conditions on the inputs:
- every programmed feedback word has P ≥ 16, which makes A < P;
- every reference value is at least 2;
- `pre_pulse` and `ref_pulse` are single-cycle enables.

Under these conditions a terminal pulse can never be followed by another one in the next cycle. The stimulus keeps to them by construction:
- it programs only legal words (256, 325, 489 and 16383 for feedback; 2, 5 and 2047 for reference);
- it generates `pre_pulse` from a behavioural ÷16/÷17 prescaler that obeys `mod_hi`;
- it draws `ref_pulse` from a pseudo-random bit stream.

// File: rtl/pll_div_pair.sv
module pll_div_pair #(
  parameter int SW_W   = 4,
  parameter int MAIN_W = 10,
  parameter int REF_W  = 11
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     pre_pulse,
  input  logic                     ref_pulse,
  input  logic [SW_W+MAIN_W-1:0]   fb_set1,
  input  logic [SW_W+MAIN_W-1:0]   fb_set2,
  input  logic [REF_W-1:0]         ref_set1,
  input  logic [REF_W-1:0]         ref_set2,
  input  logic                     sel_bit,
  input  logic                     sel_pin,
  input  logic                     sel_drv,
  output logic                     mod_hi,
  output logic                     fb_out,
  output logic                     ref_out
);
  localparam int M_W = SW_W + MAIN_W;

  logic              use_set1;
  logic [M_W-1:0]    fb_pick;
  logic [REF_W-1:0]  ref_pick;
  logic [SW_W-1:0]   sw_lim;
  logic [MAIN_W-1:0] main_lim, main_cnt;
  logic [REF_W-1:0]  ref_lim, ref_cnt;
  logic              fb_wrap, ref_wrap;

  assign use_set1 = sel_drv ? sel_pin : sel_bit;
  assign fb_pick  = use_set1 ? fb_set1  : fb_set2;
  assign ref_pick = use_set1 ? ref_set1 : ref_set2;

  assign fb_wrap  = pre_pulse && (main_cnt == main_lim - MAIN_W'(1));
  assign ref_wrap = ref_pulse && (ref_cnt == ref_lim - REF_W'(1));

  assign mod_hi = main_cnt < {{(MAIN_W-SW_W){1'b0}}, sw_lim};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      main_cnt <= '0;
      fb_out   <= 1'b0;
      sw_lim   <= fb_pick[SW_W-1:0];
      main_lim <= fb_pick[M_W-1:SW_W];
    end else begin
      fb_out <= fb_wrap;
      if (fb_wrap) begin
        main_cnt <= '0;
        sw_lim   <= fb_pick[SW_W-1:0];
        main_lim <= fb_pick[M_W-1:SW_W];
      end else if (pre_pulse) begin
        main_cnt <= main_cnt + MAIN_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_cnt <= '0;
      ref_out <= 1'b0;
      ref_lim <= ref_pick;
    end else begin
      ref_out <= ref_wrap;
      if (ref_wrap) begin
        ref_cnt <= '0;
        ref_lim <= ref_pick;
      end else if (ref_pulse) begin
        ref_cnt <= ref_cnt + REF_W'(1);
      end
    end
  end
endmodule

// File: rtl/pll_div_pair_chk.sv
module pll_div_pair_chk (
  input logic clk,
  input logic rst_n,
  input logic pre_pulse,
  input logic ref_pulse,
  input logic mod_hi,
  input logic fb_out,
  input logic ref_out
);
  AST_FB_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    fb_out |=> !fb_out); // R5
  AST_REF_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    ref_out |=> !ref_out); // R6
  AST_FB_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fb_out) |-> $past(pre_pulse)); // R9
  AST_REF_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ref_out) |-> $past(ref_pulse)); // R9
  AST_MOD_MOVES_ON_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && $past(rst_n) && !$past(pre_pulse)) |-> $stable(mod_hi)); // R3
endmodule

bind pll_div_pair pll_div_pair_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pre_pulse(pre_pulse), .ref_pulse(ref_pulse),
  .mod_hi(mod_hi), .fb_out(fb_out), .ref_out(ref_out)
);

// File: tb/pll_div_pair_bench.sv
`timescale 1ns/1ps
module pll_div_pair_bench;
  logic clk = 0, rst_n = 0, pre_pulse = 0, ref_pulse = 0;
  logic [13:0] fb_set1, fb_set2;
  logic [10:0] ref_set1, ref_set2;
  logic sel_bit, sel_pin, sel_drv;
  logic mod_hi, fb_out, ref_out;

  always #4 clk = ~clk;

  pll_div_pair u_pll_div_pair (
    .clk(clk), .rst_n(rst_n), .pre_pulse(pre_pulse), .ref_pulse(ref_pulse),
    .fb_set1(fb_set1), .fb_set2(fb_set2), .ref_set1(ref_set1), .ref_set2(ref_set2),
    .sel_bit(sel_bit), .sel_pin(sel_pin), .sel_drv(sel_drv),
    .mod_hi(mod_hi), .fb_out(fb_out), .ref_out(ref_out));

  int n_cmp = 0, n_bad = 0;
  bit live = 0, stall = 0, done = 0;
  int mtc, np, pcnt, plen, rtc, a_exp, p_exp, r_exp;
  int fb_events = 0, ref_events = 0, meas_gap = 0, meas_rgap = 0;
  bit tick_prev, pre_prev, rp_prev, vco_en;
  logic [13:0] snap_m;
  logic [10:0] snap_r;
  logic [7:0] lfsr = 8'hA5;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic bit pick1();
    return sel_drv ? sel_pin : sel_bit;  // R7
  endfunction

  always @(negedge clk) begin
    bit exp_fb, exp_ref, exp_mod;
    if (!rst_n) begin
      chk(fb_out == 0 && ref_out == 0, "R1 outputs low in reset", {fb_out, ref_out}, 0);
    end else if (!live) begin
      live = 1;
      snap_m = pick1() ? fb_set1 : fb_set2;
      snap_r = pick1() ? ref_set1 : ref_set2;
      a_exp = int'(snap_m[3:0]); p_exp = int'(snap_m[13:4]); r_exp = int'(snap_r);
      mtc = 0; np = 0; rtc = 0; pcnt = 0;
      chk(mod_hi == (a_exp != 0), "R1 mod_hi after reset", mod_hi, a_exp != 0);
      plen = mod_hi ? 17 : 16;
      tick_prev = 0; pre_prev = 0; rp_prev = 0;
    end else begin
      if (tick_prev) mtc++;
      exp_fb = 0; exp_ref = 0;
      if (pre_prev) begin
        np++;
        if (np == p_exp) begin
          exp_fb = 1;
          chk(mtc == 16 * p_exp + a_exp, "R4 oscillator periods per feedback cycle", mtc, 16 * p_exp + a_exp);
          meas_gap = mtc; fb_events++;
          np = 0; mtc = 0;
          a_exp = int'(snap_m[3:0]); p_exp = int'(snap_m[13:4]);  // R2 field split, R8 load at wrap
        end
      end
      exp_mod = np < a_exp;
      if (rp_prev) begin
        rtc++;
        if (rtc == r_exp) begin
          exp_ref = 1; meas_rgap = rtc; ref_events++;
          rtc = 0; r_exp = int'(snap_r);
        end
      end
      chk(fb_out == exp_fb, "R5 fb_out", fb_out, exp_fb);
      chk(ref_out == exp_ref, "R6 ref_out", ref_out, exp_ref);
      chk(mod_hi == exp_mod, "R3 mod_hi", mod_hi, exp_mod);
      if (pre_prev) begin pcnt = 0; plen = mod_hi ? 17 : 16; end
      else if (tick_prev) pcnt++;
    end
    if (live) begin
      vco_en = !stall;
      pre_pulse = vco_en && (pcnt == plen - 1);
      ref_pulse = !stall && lfsr[0];
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      tick_prev = vco_en; pre_prev = pre_pulse; rp_prev = ref_pulse;
      snap_m = pick1() ? fb_set1 : fb_set2;
      snap_r = pick1() ? ref_set1 : ref_set2;
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic wait_fb(input int n);
    while (fb_events < n) @(posedge clk);
    #2;
  endtask

  task automatic wait_ref(input int n);
    while (ref_events < n) @(posedge clk);
    #2;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
    end
  end

  initial begin
    int n0;
    bit m0;
    fb_set1 = {10'd20, 4'd5};  fb_set2 = {10'd16, 4'd0};
    ref_set1 = 11'd5;          ref_set2 = 11'd2;
    sel_bit = 1; sel_pin = 0; sel_drv = 0;
    step(6);
    rst_n = 1;
    // R2 R7: bit selects set 1, M = 16*20+5
    step(1500);
    chk(meas_gap == 325, "R2 R7 set1 period", meas_gap, 325);
    chk(meas_rgap == 5, "R6 R7 set1 ref period", meas_rgap, 5);
    // R7 R10: bit selects set 2, M = 256 (A = 0), R = 2
    sel_bit = 0;
    step(1500);
    chk(meas_gap == 256, "R7 R10 set2 minimum M", meas_gap, 256);
    chk(meas_rgap == 2, "R6 R10 minimum R", meas_rgap, 2);
    // R7: driven pin overrides bit
    sel_drv = 1; sel_pin = 1;
    step(1500);
    chk(meas_gap == 325, "R7 pin high overrides bit", meas_gap, 325);
    sel_bit = 1; sel_pin = 0;
    step(1500);
    chk(meas_gap == 256, "R7 pin low overrides bit", meas_gap, 256);
    // R9: no enables, nothing moves
    n0 = fb_events; m0 = mod_hi;
    stall = 1;
    step(80);
    chk(fb_events == n0 && mod_hi == m0, "R9 stall holds state", fb_events - n0, 0);
    stall = 0;
    // R8: change the selected set's value mid-period
    sel_drv = 0; sel_bit = 1;
    step(900);
    n0 = fb_events;
    step(37);
    fb_set1 = {10'd30, 4'd9};
    wait_fb(n0 + 1);
    chk(meas_gap == 325, "R8 running period keeps old value", meas_gap, 325);
    wait_fb(n0 + 2);
    chk(meas_gap == 489, "R8 new value after wrap", meas_gap, 489);
    // R10: maxima
    fb_set1 = {10'd1023, 4'd15}; ref_set1 = 11'd2047;
    n0 = fb_events;
    wait_fb(n0 + 2);
    chk(meas_gap == 16383, "R10 maximum M", meas_gap, 16383);
    n0 = ref_events;
    wait_ref(n0 + 2);
    chk(meas_rgap == 2047, "R10 maximum R", meas_rgap, 2047);
    done = 1;
    summary();
  end
endmodule